// File: doc/BRIEF.md
# Out-of-Order Event Reassembly Engine

This block rebuilds event buffers from UDP payloads that carry a 20-byte reassembly header in front of their data. An upstream parser presents the header as one 160-bit word, together with the number of data bytes that follow it. The data bytes then arrive one per cycle. Each packet belongs to an event, identified by a 64-bit tick, and carries the byte position of its data inside that event's buffer and the event's total size. Packets of one event may come in any order. Packets of two events may be interleaved.

The engine keeps a small set of tick slots, each with its own region of on-chip buffer. It writes every accepted byte at its stated position and counts the bytes that have landed for each slot. When the count equals the declared size, the slot is flagged ready. A consumer then drains the slot through a byte-wide read port and releases it. Packets that do not fit are rejected with an error pulse. Packets that find no slot are dropped and counted. Slots that stop receiving traffic are abandoned after a programmable number of cycles.

Top module: `rsm_event_assembler`

## Requirements
- R1: The header word is laid out from its most significant end as: version (bits 159:156), reserved (155:144), data id (143:128), byte offset (127:96), total length (95:64), tick (63:0). A packet whose data id differs from `cfg_data_id` is ignored entirely: no byte is written, no slot changes, and neither `err_pulse` nor `drop_pulse` is raised.
- R2: Each accepted data byte is stored at the header offset plus its index within the packet, inside the slot's buffer region. Setting `rd_sel`/`rd_addr` returns that byte on `rd_data` one clock later.
- R3: Packets are accepted in any offset order, and packets of different ticks may be interleaved. A tick that matches no slot claims the lowest-numbered free slot.
- R4: A slot's bit in `ready_mask` rises on the clock edge that stores the byte bringing its received count to the declared length. `rd_tick` and `rd_len` then show that slot's tick and length.
- R5: A `rd_free` pulse for a ready slot clears its `ready_mask` bit on the next edge, and the slot becomes free for a new tick.
- R6: A packet with a new tick when no slot is free raises `drop_pulse` for one cycle and increments `drop_count`, which saturates at its maximum.
- R7: A packet is rejected with a one-cycle `err_pulse`, and none of its bytes are stored or counted, if its length is zero, its length exceeds `BUF_BYTES`, or its offset plus payload size exceeds the length. A rejected new tick claims no slot.
- R8: A busy, not-ready slot that receives no header for `cfg_timeout` consecutive cycles is freed, and `tout_pulse` is raised for one cycle.
- R9: A packet whose tick matches a slot that is already ready is rejected with `err_pulse`.
- R10: The length declared by the first accepted packet of a tick governs the slot. The fit check for later packets of that tick uses the stored length, not their own length field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_data_id | input | 16 | Data id this engine accepts |
| cfg_timeout | input | TIMER_W | Idle cycles before a slot is abandoned |
| hdr_valid | input | 1 | Header word valid; accepted only between packets |
| hdr | input | 160 | Reassembly header word |
| hdr_pay_bytes | input | 16 | Number of data bytes following this header |
| dat_valid | input | 1 | Data byte valid |
| dat | input | 8 | Data byte |
| rd_sel | input | SLOT_W | Slot selected for drain, tick and length |
| rd_addr | input | ADDR_W | Byte address within the selected slot |
| rd_free | input | 1 | Release the selected slot after draining |
| rd_data | output | 8 | Byte read, one cycle after the address |
| rd_tick | output | 64 | Tick held by the selected slot |
| rd_len | output | LEN_W | Declared length of the selected slot |
| ready_mask | output | NUM_SLOTS | One bit per complete slot |
| err_pulse | output | 1 | Packet rejected for size or for a finished tick |
| drop_pulse | output | 1 | Packet dropped because no slot was free |
| tout_pulse | output | 1 | A slot was abandoned after going idle |
| drop_count | output | DROP_W | Saturating count of dropped packets |

## Verification
The bench builds the engine with its defaults: two slots of 64 bytes each, a 16-bit idle timer and a 16-bit drop counter. With only two slots, a third concurrent tick is enough to force the drop path. A 100-byte length field exceeds the region size and exercises the capacity rejection. The idle limit is first kept at 1000 so that no slot times out during the functional tests. It is then lowered to 20, which brings abandonment within a few dozen cycles and also covers a limit that falls below a counter already running.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
    // Reassembly header, most significant field first (first on the wire)
    typedef struct packed {
        logic [3:0]  version;
        logic [11:0] rsvd;
        logic [15:0] data_id;
        logic [31:0] offset;
        logic [31:0] length;
        logic [63:0] tick;
    } rsm_hdr_t;

    localparam int HDR_BITS = $bits(rsm_hdr_t);
endpackage

// File: rtl/rsm_fit_chk.sv
// Decides whether a packet's byte range lies inside a usable event length.
module rsm_fit_chk #(
    parameter int BUF_BYTES = 64
) (
    input  logic [31:0] off_i,
    input  logic [15:0] pay_i,
    input  logic [31:0] lim_i,
    output logic        ok_o
);
    logic [32:0] end_pos;
    always_comb begin
        end_pos = {1'b0, off_i} + {17'd0, pay_i};
        ok_o    = (lim_i != 32'd0) &&
                  (lim_i <= 32'(BUF_BYTES)) &&
                  (end_pos <= {1'b0, lim_i});
    end
endmodule

// File: rtl/rsm_idle_timer.sv
// Per-slot idle counter: cleared by kick or when not running.
module rsm_idle_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          kick_i,
    input  logic [CW-1:0] limit_i,
    output logic          expire_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (kick_i || !run_i)  cnt_d = '0;
        else if (cnt_q != '1)  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire_o = run_i && (cnt_q >= limit_i);
endmodule

// File: rtl/rsm_ev_buf.sv
// Event byte storage with one write port and a registered read port.
module rsm_ev_buf #(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
        rdata_q <= mem_q[raddr_i];
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/rsm_event_assembler.sv
module rsm_event_assembler
    import rsm_pkg::*;
#(
    parameter int NUM_SLOTS = 2,
    parameter int BUF_BYTES = 64,
    parameter int TIMER_W   = 16,
    parameter int DROP_W    = 16,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int ADDR_W   = $clog2(BUF_BYTES),
    localparam int LEN_W    = ADDR_W + 1,
    localparam int MEM_AW   = SLOT_W + ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [15:0]          cfg_data_id,
    input  logic [TIMER_W-1:0]   cfg_timeout,
    input  logic                 hdr_valid,
    input  logic [HDR_BITS-1:0]  hdr,
    input  logic [15:0]          hdr_pay_bytes,
    input  logic                 dat_valid,
    input  logic [7:0]           dat,
    input  logic [SLOT_W-1:0]    rd_sel,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  logic                 rd_free,
    output logic [7:0]           rd_data,
    output logic [63:0]          rd_tick,
    output logic [LEN_W-1:0]     rd_len,
    output logic [NUM_SLOTS-1:0] ready_mask,
    output logic                 err_pulse,
    output logic                 drop_pulse,
    output logic                 tout_pulse,
    output logic [DROP_W-1:0]    drop_count
);
    typedef struct packed {
        logic             busy;
        logic             ready;
        logic [63:0]      tick;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] cnt;
    } slot_t;

    typedef struct packed {
        slot_t [NUM_SLOTS-1:0] slot;
        logic                  rx;
        logic                  keep;
        logic [SLOT_W-1:0]     rs;
        logic [ADDR_W-1:0]     wptr;
        logic [15:0]           left;
        logic                  err;
        logic                  drop;
        logic                  tout;
        logic [DROP_W-1:0]     dcnt;
    } state_t;

    state_t st_d, st_q;

    rsm_hdr_t h;
    assign h = rsm_hdr_t'(hdr);

    // ---------------- slot lookup ----------------
    logic [NUM_SLOTS-1:0] hit, run, kick, expire;
    logic                 hit_any, free_any;
    logic [SLOT_W-1:0]    hit_idx, free_idx;

    always_comb begin
        hit_any  = 1'b0;
        free_any = 1'b0;
        hit_idx  = '0;
        free_idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            hit[i] = st_q.slot[i].busy && (st_q.slot[i].tick == h.tick);
            if (hit[i]) begin
                hit_any = 1'b1;
                hit_idx = SLOT_W'(i);
            end
            if (!st_q.slot[i].busy) begin
                free_any = 1'b1;
                free_idx = SLOT_W'(i);
            end
        end
    end

    // ---------------- fit check ----------------
    logic [31:0] lim;
    logic        fit_ok;
    assign lim = hit_any ? {{(32-LEN_W){1'b0}}, st_q.slot[hit_idx].len} : h.length;

    rsm_fit_chk #(.BUF_BYTES(BUF_BYTES)) u_fit (
        .off_i (h.offset),
        .pay_i (hdr_pay_bytes),
        .lim_i (lim),
        .ok_o  (fit_ok)
    );

    logic take_hdr, id_match;
    assign take_hdr = hdr_valid && !st_q.rx;
    assign id_match = (h.data_id == cfg_data_id);

    // ---------------- idle timers ----------------
    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            run[i]  = st_q.slot[i].busy && !st_q.slot[i].ready &&
                      !(st_q.rx && st_q.keep && (st_q.rs == SLOT_W'(i)));
            kick[i] = take_hdr && id_match &&
                      ((hit_any && hit_idx == SLOT_W'(i)) ||
                       (!hit_any && free_any && fit_ok && free_idx == SLOT_W'(i)));
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_tmr
        rsm_idle_timer #(.CW(TIMER_W)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .run_i    (run[g]),
            .kick_i   (kick[g]),
            .limit_i  (cfg_timeout),
            .expire_o (expire[g])
        );
    end

    // ---------------- next state ----------------
    logic              we;
    logic [MEM_AW-1:0] waddr;
    logic [LEN_W-1:0]  cnt_new;

    always_comb begin
        st_d      = st_q;
        st_d.err  = 1'b0;
        st_d.drop = 1'b0;
        st_d.tout = 1'b0;
        we        = 1'b0;
        waddr     = {st_q.rs, st_q.wptr};
        cnt_new   = st_q.slot[st_q.rs].cnt + 1'b1;

        // abandonment of idle slots; a header hitting the slot wins
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (expire[i] && !(take_hdr && id_match && hit[i])) begin
                st_d.slot[i].busy = 1'b0;
                st_d.tout         = 1'b1;
            end
        end

        // release after drain
        if (rd_free && st_q.slot[rd_sel].ready) begin
            st_d.slot[rd_sel].busy  = 1'b0;
            st_d.slot[rd_sel].ready = 1'b0;
        end

        // header acceptance
        if (take_hdr) begin
            st_d.rx   = (hdr_pay_bytes != 16'd0);
            st_d.keep = 1'b0;
            st_d.left = hdr_pay_bytes;
            st_d.wptr = h.offset[ADDR_W-1:0];
            if (id_match) begin
                if (hit_any) begin
                    if (st_q.slot[hit_idx].ready || !fit_ok) begin
                        st_d.err = 1'b1;
                    end else begin
                        st_d.keep = 1'b1;
                        st_d.rs   = hit_idx;
                    end
                end else if (free_any) begin
                    if (!fit_ok) begin
                        st_d.err = 1'b1;
                    end else begin
                        st_d.keep                 = 1'b1;
                        st_d.rs                   = free_idx;
                        st_d.slot[free_idx].busy  = 1'b1;
                        st_d.slot[free_idx].ready = 1'b0;
                        st_d.slot[free_idx].tick  = h.tick;
                        st_d.slot[free_idx].len   = h.length[LEN_W-1:0];
                        st_d.slot[free_idx].cnt   = '0;
                    end
                end else begin
                    st_d.drop = 1'b1;
                    if (st_q.dcnt != '1) st_d.dcnt = st_q.dcnt + 1'b1;
                end
            end
        end

        // data bytes
        if (st_q.rx && dat_valid) begin
            if (st_q.keep) begin
                we                     = 1'b1;
                st_d.slot[st_q.rs].cnt = cnt_new;
                if (cnt_new == st_q.slot[st_q.rs].len)
                    st_d.slot[st_q.rs].ready = 1'b1;
            end
            st_d.wptr = st_q.wptr + 1'b1;
            st_d.left = st_q.left - 1'b1;
            if (st_q.left == 16'd1) st_d.rx = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // ---------------- storage ----------------
    rsm_ev_buf #(.DEPTH(NUM_SLOTS * BUF_BYTES), .DW(8)) u_buf (
        .clk     (clk),
        .we_i    (we),
        .waddr_i (waddr),
        .wdata_i (dat),
        .raddr_i ({rd_sel, rd_addr}),
        .rdata_o (rd_data)
    );

    // ---------------- outputs ----------------
    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) ready_mask[i] = st_q.slot[i].ready;
    end
    assign rd_tick    = st_q.slot[rd_sel].tick;
    assign rd_len     = st_q.slot[rd_sel].len;
    assign err_pulse  = st_q.err;
    assign drop_pulse = st_q.drop;
    assign tout_pulse = st_q.tout;
    assign drop_count = st_q.dcnt;

    // ---------------- assertions ----------------
    // R7: a stored byte never lands at or past the slot's declared length
    assert_write_in_bounds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (LEN_W'(st_q.wptr) < st_q.slot[st_q.rs].len));

    // R6: every drop pulse comes with one more counted drop (or saturation)
    assert_drop_counted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_pulse && $past(rst_n)) |->
            ((drop_count == $past(drop_count) + 1'b1) || (drop_count == '1)));

    // R5: releasing a ready slot clears its ready bit on the next edge
    assert_free_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_free && ready_mask[rd_sel]) |=> !ready_mask[$past(rd_sel)]);

    // R8: no abandonment pulse unless a slot was busy and still filling
    assert_timeout_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tout_pulse) |-> ($countones($past(run)) != 0));

    for (genvar a = 0; a < NUM_SLOTS; a++) begin : g_chk
        // R4: a slot becomes ready only with its full byte count
        assert_ready_on_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_q.slot[a].ready) |-> (st_q.slot[a].cnt == st_q.slot[a].len));
        // R3: a ready slot is always an occupied slot
        assert_ready_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.slot[a].ready |-> st_q.slot[a].busy);
    end
endmodule

// File: tb/tb_rsm_event_assembler.sv
module tb_rsm_event_assembler;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] MY_ID = 16'h0042;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [15:0]  cfg_data_id;
    logic [15:0]  cfg_timeout;
    logic         hdr_valid;
    logic [159:0] hdr;
    logic [15:0]  hdr_pay_bytes;
    logic         dat_valid;
    logic [7:0]   dat;
    logic [0:0]   rd_sel;
    logic [5:0]   rd_addr;
    logic         rd_free;
    logic [7:0]   rd_data;
    logic [63:0]  rd_tick;
    logic [6:0]   rd_len;
    logic [1:0]   ready_mask;
    logic         err_pulse, drop_pulse, tout_pulse;
    logic [15:0]  drop_count;

    int checks = 0;
    int fails  = 0;
    logic tout_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsm_event_assembler dut (
        .clk(clk), .rst_n(rst_n), .cfg_data_id(cfg_data_id), .cfg_timeout(cfg_timeout),
        .hdr_valid(hdr_valid), .hdr(hdr), .hdr_pay_bytes(hdr_pay_bytes),
        .dat_valid(dat_valid), .dat(dat), .rd_sel(rd_sel), .rd_addr(rd_addr),
        .rd_free(rd_free), .rd_data(rd_data), .rd_tick(rd_tick), .rd_len(rd_len),
        .ready_mask(ready_mask), .err_pulse(err_pulse), .drop_pulse(drop_pulse),
        .tout_pulse(tout_pulse), .drop_count(drop_count)
    );

    always @(posedge clk) if (tout_pulse) tout_seen <= 1'b1;

    // {tick[7:0], off[7:0], pay[7:0], len[7:0], exp_err, exp_mask[1:0]}
    localparam int NVEC = 5;
    localparam logic [34:0] VEC [NVEC] = '{
        {8'd10, 8'd8,  8'd8, 8'd20, 1'b0, 2'b00},
        {8'd20, 8'd0,  8'd6, 8'd6,  1'b0, 2'b10},
        {8'd10, 8'd0,  8'd8, 8'd20, 1'b0, 2'b10},
        {8'd10, 8'd16, 8'd8, 8'd20, 1'b1, 2'b10},
        {8'd10, 8'd16, 8'd4, 8'd20, 1'b0, 2'b11}
    };

    function automatic logic [7:0] pat(input logic [7:0] t, input int p);
        return t ^ 8'(p * 7 + 1);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_pkt(input logic [15:0] did, input logic [63:0] tick, input logic [31:0] off,
                            input logic [31:0] len, input logic [15:0] pay, input bit alt,
                            output logic e, output logic d);
        @(negedge clk);
        hdr_valid     = 1'b1;
        hdr           = {4'd1, 12'd0, did, off, len, tick};
        hdr_pay_bytes = pay;
        @(posedge clk);
        @(negedge clk);
        hdr_valid = 1'b0;
        e = err_pulse;
        d = drop_pulse;
        for (int i = 0; i < int'(pay); i++) begin
            dat_valid = 1'b1;
            dat = alt ? ~pat(tick[7:0], int'(off) + i) : pat(tick[7:0], int'(off) + i);
            @(posedge clk);
            @(negedge clk);
        end
        dat_valid = 1'b0;
    endtask

    task automatic rd_byte(input logic s, input int a, output logic [7:0] v);
        @(negedge clk);
        rd_sel  = s;
        rd_addr = 6'(a);
        @(posedge clk);
        @(negedge clk);
        v = rd_data;
    endtask

    task automatic free_slot(input logic s);
        @(negedge clk);
        rd_sel  = s;
        rd_free = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_free = 1'b0;
    endtask

    task automatic chk_event(input logic s, input logic [7:0] t, input int len, input string req);
        logic [7:0] v;
        for (int p = 0; p < len; p++) begin
            rd_byte(s, p, v);
            chk(v == pat(t, p), req, v, pat(t, p));
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic e, d;
        rst_n = 1'b0; cfg_data_id = MY_ID; cfg_timeout = 16'd1000;
        hdr_valid = 1'b0; hdr = '0; hdr_pay_bytes = '0; dat_valid = 1'b0; dat = '0;
        rd_sel = '0; rd_addr = '0; rd_free = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk(ready_mask == 2'b00, "reset ready_mask", ready_mask, 0);
        chk(drop_count == 16'd0, "reset drop_count", drop_count, 0);
        chk(!err_pulse && !drop_pulse && !tout_pulse, "reset pulses", {err_pulse, drop_pulse, tout_pulse}, 0);

        // table walk: out of order, interleaved ticks (R2 R3 R4 R7 R10)
        for (int k = 0; k < NVEC; k++) begin
            send_pkt(MY_ID, 64'(VEC[k][34:27]), 32'(VEC[k][26:19]), 32'(VEC[k][10:3]),
                     16'(VEC[k][18:11]), 1'b0, e, d);
            chk(e == VEC[k][2], "R7 vector err", e, VEC[k][2]);
            chk(!d, "R6 vector no drop", d, 0);
            chk(ready_mask == VEC[k][1:0], "R3 R4 vector ready_mask", ready_mask, VEC[k][1:0]);
        end
        @(negedge clk); rd_sel = 1'b0;
        chk(rd_tick == 64'd10 && rd_len == 7'd20, "R4 slot0 tick/len", {rd_tick[31:0], 25'd0, rd_len}, {32'd10, 25'd0, 7'd20});
        chk_event(1'b0, 8'd10, 20, "R2 slot0 data");
        chk_event(1'b1, 8'd20, 6, "R2 slot1 data");

        free_slot(1'b1);
        chk(ready_mask == 2'b01, "R5 free slot1", ready_mask, 2'b01);
        free_slot(1'b0);
        chk(ready_mask == 2'b00, "R5 free slot0", ready_mask, 2'b00);

        // R6: third tick with both slots busy
        send_pkt(MY_ID, 64'd30, 32'd0, 32'd10, 16'd2, 1'b0, e, d);
        send_pkt(MY_ID, 64'd31, 32'd0, 32'd10, 16'd2, 1'b0, e, d);
        chk(!d && !e, "R5 slots reusable", {e, d}, 0);
        send_pkt(MY_ID, 64'd32, 32'd0, 32'd10, 16'd2, 1'b0, e, d);
        chk(d == 1'b1, "R6 drop pulse", d, 1);
        chk(drop_count == 16'd1, "R6 drop_count", drop_count, 1);

        // R1: foreign data id ignored
        send_pkt(16'h0099, 64'd30, 32'd2, 32'd10, 16'd8, 1'b1, e, d);
        chk(!e && !d, "R1 foreign id no pulse", {e, d}, 0);
        chk(ready_mask == 2'b00, "R1 foreign id no completion", ready_mask, 0);
        send_pkt(MY_ID, 64'd30, 32'd2, 32'd10, 16'd8, 1'b0, e, d);
        chk(ready_mask == 2'b01, "R1 R4 tick30 complete", ready_mask, 2'b01);
        chk_event(1'b0, 8'd30, 10, "R1 tick30 data");

        // R9: packet for a finished tick
        send_pkt(MY_ID, 64'd30, 32'd0, 32'd10, 16'd1, 1'b0, e, d);
        chk(e == 1'b1, "R9 finished tick err", e, 1);

        // R10: stored length governs (10), header claims 40
        send_pkt(MY_ID, 64'd31, 32'd2, 32'd40, 16'd12, 1'b0, e, d);
        chk(e == 1'b1, "R10 stored length err", e, 1);
        chk(ready_mask == 2'b01, "R10 no completion", ready_mask, 2'b01);

        // R7: length beyond region size claims no slot
        free_slot(1'b0);
        send_pkt(MY_ID, 64'd40, 32'd0, 32'd100, 16'd4, 1'b0, e, d);
        chk(e == 1'b1, "R7 oversize length err", e, 1);
        send_pkt(MY_ID, 64'd42, 32'd0, 32'd4, 16'd4, 1'b0, e, d);
        chk(!d && !e, "R7 rejected tick left slot free", {e, d}, 0);
        chk(ready_mask == 2'b01, "R7 R4 tick42 complete", ready_mask, 2'b01);
        @(negedge clk); rd_sel = 1'b0;
        chk(rd_tick == 64'd42 && rd_len == 7'd4, "R4 tick42 tick/len", {rd_tick[31:0], 25'd0, rd_len}, {32'd42, 25'd0, 7'd4});

        // R8: idle tick31 abandoned after the limit drops
        chk(!tout_seen, "R8 no early timeout", tout_seen, 0);
        free_slot(1'b0);
        @(negedge clk); cfg_timeout = 16'd20;
        repeat (40) @(negedge clk);
        chk(tout_seen, "R8 timeout pulse", tout_seen, 1);
        send_pkt(MY_ID, 64'd50, 32'd0, 32'd8, 16'd2, 1'b0, e, d);
        chk(!d, "R8 tick50 slot", d, 0);
        send_pkt(MY_ID, 64'd51, 32'd0, 32'd8, 16'd2, 1'b0, e, d);
        chk(!d, "R8 abandoned slot reused", d, 0);
        chk(drop_count == 16'd1, "R6 drop_count unchanged", drop_count, 1);

        summary();
    end
endmodule